// File: doc/BRIEF.md
# Bit-manipulation Integer ALU

A 64-bit integer execution unit for the scalar datapath of a processor core. Each cycle it accepts two operands and a 7-bit operation code and produces a 64-bit result and a branch-taken flag. The three high opcode bits choose an operation family. The low four bits choose the member within that family. The operations cover shifts and rotates, single-bit manipulation, 32-bit word forms, fused address additions, comparisons with minimum and maximum, logic with inverted operands, byte-level rearrangement, narrowed logic results and branch condition evaluation.

The datapath is purely combinational. One output register stage follows it, so a result appears one clock after its operands are presented. The register clears asynchronously on reset. Any opcode outside the defined set produces a zero result and a low branch flag, so a decoder upstream can rely on a harmless result for illegal codes.

Top module: `bitmanip_alu`

## Requirements
- R1: While `rst_n` is low, `result` and `taken` are zero. After reset, both outputs show the value computed from `op`, `src_a` and `src_b` as they stood at the previous rising clock edge.
- R2: The 64-bit shifts and rotates use only `src_b[5:0]` as the shift amount: 0000001 shift left, 0000101 logical shift right, 0000111 arithmetic shift right, 0001001 rotate left, 0001011 rotate right. Opcode 0000000 zero-extends `src_a[31:0]` and then shifts it left.
- R3: The single-bit operations use `src_b[5:0]` as the bit index: 0000010 clears that bit of `src_a`, 0000011 sets it and 0000100 inverts it. Opcode 0000110 returns that bit in bit 0, with all other result bits zero.
- R4: The word operations compute on 32 bits and sign-extend bit 31 of the result to 64 bits: 0010000 add, 0010010 subtract, 0011000 shift left, 0011001 logical shift right, 0011010 arithmetic shift right of `src_a[31:0]`, 0011100 rotate left and 0011101 rotate right. The word shifts and rotates use only `src_b[4:0]` as the amount.
- R5: The add family returns `src_b` plus a modified `src_a`. Opcode 0100001 adds `src_a` unchanged. Opcode 0100000 adds the zero-extended `src_a[31:0]`. Opcodes 0100100 to 0100111 add `src_a` shifted right by 29, 30, 31 or 32. Opcodes 0101001, 0101011, 0101101 and 0101111 add `src_a` shifted left by 1, 2, 3 or 4. Opcodes 0101000, 0101010 and 0101100 add the zero-extended `src_a[31:0]` shifted left by 1, 2 or 3.
- R6: The compare family works from `src_a - src_b`: 0110000 returns the difference, 0110001 and 0110010 return 1 when `src_a` is less than `src_b` (unsigned and signed) and 0 otherwise, 0110100 and 0110110 return the larger operand (unsigned and signed), and 0110101 and 0110111 return the smaller one.
- R7: The logic and misc codes are: 1000000 AND, 1000001 AND with inverted `src_b`, 1000010 OR, 1000011 OR with inverted `src_b`, 1000100 XOR, 1000101 XNOR. Opcode 1000110 sets each byte to 0xFF when that byte of `src_a` is nonzero and to 0x00 otherwise. Opcodes 1001000 and 1001010 sign-extend the low byte and the low halfword of `src_a`. Opcode 1001001 returns {`src_b[7:0]`,`src_a[7:0]`} zero-extended. Opcode 1001011 returns {`src_b[15:0]`,`src_a[15:0]`} sign-extended from bit 31. Opcode 1010010 returns {`src_b[31:0]`,`src_a[31:0]`}. Opcode 1010001 reverses the byte order of `src_a`.
- R8: In family 110, bits [3:1] pick the logic operation: 000 AND, 001 OR, 010 XOR, 011 byte OR-combine. With opcode bit 0 clear, the result is bit 0 of that logic result. With bit 0 set, the result is the zero-extended low 16 bits.
- R9: In family 111 with opcode bit 0 clear, bits [3:2] select the compare: 00 equal, 10 signed less-than, 11 unsigned less-than. Bit 1 inverts the condition, and `taken` carries the outcome. Branch opcodes always return a zero result.
- R10: Every opcode not listed in R2 to R9 produces a zero result and a low `taken`. `taken` is low for every opcode outside family 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 7 | Operation code, family in bits [6:4] |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, also shift amount or bit index |
| result | output | 64 | Registered result |
| taken | output | 1 | Registered branch condition outcome |

## Verification
The signed less-than decision and the subtraction result both come from one difference. A signed compare or branch on operands of opposite sign, where the subtraction overflows, exercises the two together. The bench applies such pairs, including the most negative value against positive numbers and equal operands, to slt, min, max, blt and bge. It checks that the result and the flag both follow the signs of the operands and not the overflowed difference bit. Rotations by zero, amounts with their upper bits set, and word arithmetic that crosses bit 31 are checked against a separate behavioural model on every clock.

// File: rtl/bitmanip_alu.sv
module bitmanip_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result,
  output logic            taken
);
  localparam int HALF = XLEN / 2;
  localparam int QTR  = XLEN / 4;
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = SHW - 1;
  localparam int NB   = XLEN / 8;
  localparam logic [SHW:0]  FULL  = XLEN[SHW:0];
  localparam logic [WSHW:0] WFULL = HALF[WSHW:0];

  function automatic logic [XLEN-1:0] sext_w(input logic [HALF-1:0] v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  logic [SHW-1:0]  sh;
  logic [WSHW-1:0] wsh;
  logic [HALF-1:0] alo;
  logic [XLEN-1:0] zlo, onehot, orcb_v, rev_v, logic_v, rol_v, ror_v;
  logic [HALF-1:0] rolw_v, rorw_v;
  logic [XLEN:0]   diff;
  logic            lt_u, lt_s, cond, cond_ok, lvalid;
  logic [XLEN-1:0] res_d;

  assign sh     = src_b[SHW-1:0];
  assign wsh    = src_b[WSHW-1:0];
  assign alo    = src_a[HALF-1:0];
  assign zlo    = {{HALF{1'b0}}, alo};
  assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << sh;
  assign diff   = {1'b0, src_a} - {1'b0, src_b};
  assign lt_u   = diff[XLEN];
  assign lt_s   = (src_a[XLEN-1] != src_b[XLEN-1]) ? src_a[XLEN-1] : diff[XLEN-1];
  assign rol_v  = (src_a << sh) | (src_a >> (FULL - {1'b0, sh}));
  assign ror_v  = (src_a >> sh) | (src_a << (FULL - {1'b0, sh}));
  assign rolw_v = (alo << wsh) | (alo >> (WFULL - {1'b0, wsh}));
  assign rorw_v = (alo >> wsh) | (alo << (WFULL - {1'b0, wsh}));

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign orcb_v[8*g +: 8] = {8{|src_a[8*g +: 8]}};
    assign rev_v[8*g +: 8]  = src_a[8*(NB-1-g) +: 8];
  end

  always_comb begin
    lvalid = 1'b1;
    case (op[3:1])
      3'b000:  logic_v = src_a & src_b;
      3'b001:  logic_v = src_a | src_b;
      3'b010:  logic_v = src_a ^ src_b;
      3'b011:  logic_v = orcb_v;
      default: begin logic_v = '0; lvalid = 1'b0; end
    endcase
  end

  always_comb begin
    cond_ok = (op[6:4] == 3'b111) && !op[0];
    case (op[3:2])
      2'b00:   cond = (src_a == src_b);
      2'b10:   cond = lt_s;
      2'b11:   cond = lt_u;
      default: begin cond = 1'b0; cond_ok = 1'b0; end
    endcase
  end

  always_comb begin
    res_d = '0;
    case (op)
      7'b0000000: res_d = zlo << sh;
      7'b0000001: res_d = src_a << sh;
      7'b0000010: res_d = src_a & ~onehot;
      7'b0000011: res_d = src_a | onehot;
      7'b0000100: res_d = src_a ^ onehot;
      7'b0000101: res_d = src_a >> sh;
      7'b0000110: res_d = {{(XLEN-1){1'b0}}, |(src_a & onehot)};
      7'b0000111: res_d = $signed(src_a) >>> sh;
      7'b0001001: res_d = rol_v;
      7'b0001011: res_d = ror_v;
      7'b0010000: res_d = sext_w(alo + src_b[HALF-1:0]);
      7'b0010010: res_d = sext_w(alo - src_b[HALF-1:0]);
      7'b0011000: res_d = sext_w(alo << wsh);
      7'b0011001: res_d = sext_w(alo >> wsh);
      7'b0011010: res_d = sext_w($signed(alo) >>> wsh);
      7'b0011100: res_d = sext_w(rolw_v);
      7'b0011101: res_d = sext_w(rorw_v);
      7'b0100000: res_d = zlo + src_b;
      7'b0100001: res_d = src_a + src_b;
      7'b0100100: res_d = (src_a >> (HALF-3)) + src_b;
      7'b0100101: res_d = (src_a >> (HALF-2)) + src_b;
      7'b0100110: res_d = (src_a >> (HALF-1)) + src_b;
      7'b0100111: res_d = (src_a >> HALF) + src_b;
      7'b0101000: res_d = (zlo << 1) + src_b;
      7'b0101001: res_d = (src_a << 1) + src_b;
      7'b0101010: res_d = (zlo << 2) + src_b;
      7'b0101011: res_d = (src_a << 2) + src_b;
      7'b0101100: res_d = (zlo << 3) + src_b;
      7'b0101101: res_d = (src_a << 3) + src_b;
      7'b0101111: res_d = (src_a << 4) + src_b;
      7'b0110000: res_d = diff[XLEN-1:0];
      7'b0110001: res_d = {{(XLEN-1){1'b0}}, lt_u};
      7'b0110010: res_d = {{(XLEN-1){1'b0}}, lt_s};
      7'b0110100: res_d = lt_u ? src_b : src_a;
      7'b0110101: res_d = lt_u ? src_a : src_b;
      7'b0110110: res_d = lt_s ? src_b : src_a;
      7'b0110111: res_d = lt_s ? src_a : src_b;
      7'b1000000: res_d = src_a & src_b;
      7'b1000001: res_d = src_a & ~src_b;
      7'b1000010: res_d = src_a | src_b;
      7'b1000011: res_d = src_a | ~src_b;
      7'b1000100: res_d = src_a ^ src_b;
      7'b1000101: res_d = ~(src_a ^ src_b);
      7'b1000110: res_d = orcb_v;
      7'b1001000: res_d = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
      7'b1001001: res_d = {{(XLEN-16){1'b0}}, src_b[7:0], src_a[7:0]};
      7'b1001010: res_d = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
      7'b1001011: res_d = sext_w({src_b[QTR-1:0], src_a[QTR-1:0]});
      7'b1010001: res_d = rev_v;
      7'b1010010: res_d = {src_b[HALF-1:0], alo};
      default: begin
        if (op[6:4] == 3'b110 && lvalid)
          res_d = op[0] ? {{(XLEN-16){1'b0}}, logic_v[15:0]}
                        : {{(XLEN-1){1'b0}}, logic_v[0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      taken  <= 1'b0;
    end else begin
      result <= res_d;
      taken  <= cond_ok && (cond ^ op[1]);
    end
  end

  // R10
  taken_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[6:4] != 3'b111) |=> !taken);
  // R9
  branch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[6:4] == 3'b111) |=> (result == '0));
  // R4
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[6:4] == 3'b001) |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));
  // R3
  bext_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 7'b0000110) |=> (result[XLEN-1:1] == '0));
  // R5
  plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 7'b0100001) |=> (result == $past(src_a) + $past(src_b)));
  // R8
  narrow_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[6:4] == 3'b110 && !op[0]) |=> (result[XLEN-1:1] == '0));
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (result == '0 && !taken));
endmodule

// File: tb/sim_bitmanip_alu.sv
`timescale 1ns/1ps
module sim_bitmanip_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [63:0] result;
  logic        taken;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitmanip_alu u0 (.clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
                   .result(result), .taken(taken));

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] rot_left(input logic [63:0] v, input int n, input int w);
    logic [63:0] t = v;
    for (int i = 0; i < n; i++) begin
      if (w == 64) t = {t[62:0], t[63]};
      else t = {32'b0, t[30:0], t[31]};
    end
    return t;
  endfunction

  function automatic logic [63:0] orc(input logic [63:0] v);
    logic [63:0] t = '0;
    for (int i = 0; i < 8; i++) if (v[8*i +: 8] != 8'h00) t[8*i +: 8] = 8'hFF;
    return t;
  endfunction

  function automatic string tag_of(input logic [6:0] o);
    case (o[6:4])
      3'b000: return (o inside {7'h02, 7'h03, 7'h04, 7'h06}) ? "R3" : "R2";
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b110: return "R8";
      3'b111: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic model(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y,
                       output logic [63:0] r, output logic t);
    int s6 = int'(y[5:0]);
    int s5 = int'(y[4:0]);
    longint sx = x, sy = y;
    logic [63:0] lg;
    bit known = 1;
    r = 0; t = 0;
    case (o)
      7'h00: r = {32'b0, x[31:0]} << s6;
      7'h01: r = x << s6;
      7'h02: begin r = x; r[s6] = 1'b0; end
      7'h03: begin r = x; r[s6] = 1'b1; end
      7'h04: begin r = x; r[s6] = ~x[s6]; end
      7'h05: r = x >> s6;
      7'h06: r = {63'b0, x[s6]};
      7'h07: r = sx >>> s6;
      7'h09: r = rot_left(x, s6, 64);
      7'h0B: r = rot_left(x, (64 - s6) % 64, 64);
      7'h10: r = sx32(x[31:0] + y[31:0]);
      7'h12: r = sx32(x[31:0] - y[31:0]);
      7'h18: r = sx32(x[31:0] << s5);
      7'h19: r = sx32(x[31:0] >> s5);
      7'h1A: r = sx32(32'($signed(x[31:0]) >>> s5));
      7'h1C: r = sx32(rot_left({32'b0, x[31:0]}, s5, 32)[31:0]);
      7'h1D: r = sx32(rot_left({32'b0, x[31:0]}, (32 - s5) % 32, 32)[31:0]);
      7'h20: r = {32'b0, x[31:0]} + y;
      7'h21: r = x + y;
      7'h24, 7'h25, 7'h26, 7'h27: r = (x >> (29 + int'(o[1:0]))) + y;
      7'h28: r = {32'b0, x[31:0]} * 2 + y;
      7'h2A: r = {32'b0, x[31:0]} * 4 + y;
      7'h2C: r = {32'b0, x[31:0]} * 8 + y;
      7'h29: r = x * 2 + y;
      7'h2B: r = x * 4 + y;
      7'h2D: r = x * 8 + y;
      7'h2F: r = x * 16 + y;
      7'h30: r = x - y;
      7'h31: r = (x < y) ? 1 : 0;
      7'h32: r = (sx < sy) ? 1 : 0;
      7'h34: r = (x > y) ? x : y;
      7'h35: r = (x < y) ? x : y;
      7'h36: r = (sx > sy) ? x : y;
      7'h37: r = (sx < sy) ? x : y;
      7'h40: r = x & y;
      7'h41: r = x & ~y;
      7'h42: r = x | y;
      7'h43: r = x | ~y;
      7'h44: r = x ^ y;
      7'h45: r = ~(x ^ y);
      7'h46: r = orc(x);
      7'h48: r = longint'(byte'(x[7:0]));
      7'h49: r = {48'b0, y[7:0], x[7:0]};
      7'h4A: r = longint'(shortint'(x[15:0]));
      7'h4B: r = sx32({y[15:0], x[15:0]});
      7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
      7'h52: r = {y[31:0], x[31:0]};
      7'h70: t = (x == y);
      7'h72: t = (x != y);
      7'h78: t = (sx < sy);
      7'h7A: t = (sx >= sy);
      7'h7C: t = (x < y);
      7'h7E: t = (x >= y);
      default: begin
        if (o[6:4] == 3'b110) begin
          case (o[3:1])
            3'd0: lg = x & y;
            3'd1: lg = x | y;
            3'd2: lg = x ^ y;
            3'd3: lg = orc(x);
            default: begin lg = 0; known = 0; end
          endcase
          if (known) r = o[0] ? {48'b0, lg[15:0]} : {63'b0, lg[0]};
        end
      end
    endcase
  endtask

  task automatic check(input string tg, input logic [63:0] er, input logic et);
    n_cmp++;
    if (result !== er || taken !== et) begin
      n_bad++;
      $display("FAIL %s op=%b result=%h taken=%b expected result=%h taken=%b",
               tg, op, result, taken, er, et);
    end
  endtask

  task automatic apply(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] er; logic et;
    op = o; src_a = x; src_b = y;
    model(o, x, y, er, et);
    @(negedge clk);
    check(tag_of(o), er, et);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pool [8];
    pool[0] = 64'h0; pool[1] = '1; pool[2] = 64'h8000_0000_0000_0000;
    pool[3] = 64'h7FFF_FFFF_FFFF_FFFF; pool[4] = 64'h0000_0000_7FFF_FFFF;
    pool[5] = 64'h0000_0000_8000_0000; pool[6] = 64'h1; pool[7] = 64'h00FF_0000_0000_1200;
    op = 7'h21; src_a = 64'h1234; src_b = 64'h1;
    repeat (3) @(negedge clk);
    check("R1", 64'h0, 1'b0);
    rst_n = 1'b1;
    apply(7'h21, 64'h5, 64'h7);                                  // R1 one-cycle latency
    apply(7'h01, 64'h1, 64'd67);                                 // R2 amount masked to 3
    apply(7'h09, 64'h8000_0000_0000_0001, 64'h0);                // R2 rotate by zero
    apply(7'h0B, 64'h1, 64'h41);                                 // R2 rotate right by 1
    apply(7'h07, 64'h8000_0000_0000_0000, 64'd63);               // R2
    apply(7'h03, 64'h0, 64'd127);                                // R3 index 63
    apply(7'h06, 64'h8000_0000_0000_0000, 64'hFFC0 | 64'd63);    // R3
    apply(7'h04, '1, 64'd0);                                     // R3
    apply(7'h10, 64'h7FFF_FFFF, 64'h1);                          // R4 crosses bit 31
    apply(7'h18, 64'h1, 64'd33);                                 // R4 amount masked to 1
    apply(7'h1A, 64'h8000_0000, 64'd4);                          // R4
    apply(7'h1C, 64'hFFFF_FFFF_8000_0001, 64'd0);                // R4 rotate by zero
    apply(7'h27, 64'hABCD_0000_0000_0000, 64'h1);                // R5
    apply(7'h2F, 64'h1000_0000_0000_0001, 64'h2);                // R5
    apply(7'h28, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);                // R5
    apply(7'h32, 64'h8000_0000_0000_0000, 64'h1);                // R6 overflowing diff
    apply(7'h36, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000); // R6
    apply(7'h31, 64'h8000_0000_0000_0000, 64'h1);                // R6
    apply(7'h78, 64'h8000_0000_0000_0000, 64'h1);                // R9 blt overflow
    apply(7'h7A, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000); // R9 bge
    apply(7'h70, 64'h55, 64'h55);                                // R9 beq equal
    apply(7'h7E, 64'h55, 64'h55);                                // R9 bgeu equal
    apply(7'h46, 64'h0100_0000_0000_0080, 64'h0);                // R7
    apply(7'h51, 64'h0102_0304_0506_0708, 64'h0);                // R7
    apply(7'h4B, 64'h8000, 64'h1234_0000_0000_ABCD);             // R7
    apply(7'h64, 64'h3, 64'h1);                                  // R8 xor low bit
    apply(7'h67, 64'h0000_0000_0001_0000, 64'h0);                // R8 orcb low halfword
    apply(7'h08, '1, '1);                                        // R10 unlisted
    apply(7'h71, 64'h1, 64'h1);                                  // R10 odd branch code
    apply(7'h68, '1, '1);                                        // R10 unlisted narrow
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] x, y;
      x = (i % 3 == 0) ? pool[$urandom_range(7)] : {$urandom, $urandom};
      case (i % 4)
        0: y = x;
        1: y = pool[$urandom_range(7)];
        default: y = {$urandom, $urandom};
      endcase
      apply(7'($urandom_range(127)), x, y);                      // R2..R10 sweep
    end
    rst_n = 1'b0;
    #1;
    check("R1", 64'h0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule